// File: doc/BRIEF.md
# Flash Program/Erase Command Sequencer

This block sits on the host side of a byte-wide parallel flash bus. A requester hands it one operation at a time over a valid/ready handshake: program one byte, erase one sector, erase the whole array, read the two identification bytes, or return the device to read mode. The sequencer expands the request into the unlock-prefixed series of bus writes the device expects. Each write and read is given a parameterised address setup, strobe pulse and hold phase. For program and erase, it then polls the target location until the operation completes or times out.

Completion is judged on data bit 7 of the polled location. When the device raises bit 5 while bit 7 still disagrees, the sequencer makes exactly one confirming read. If bit 7 still disagrees, it writes the return-to-read command and reports an error. A one-cycle done or error pulse ends every request. Identification bytes stay on a 16-bit output until the next identification read.

Top module: `flash_seq`

## Requirements
- R1: After reset, req_ready_o is 1, fl_we_no and fl_oe_no are 1, fl_dq_oe_o is 0, and done_o and err_o are 0.
- R2: Operation code 1 (program) issues four writes (address:data): 555h:AAh, 2AAh:55h, 555h:A0h, then req_addr_i:req_data_i.
- R3: Operation code 2 (sector erase) issues six writes: 555h:AAh, 2AAh:55h, 555h:80h, 555h:AAh, 2AAh:55h, then req_addr_i:30h.
- R4: Operation code 3 (chip erase) issues the same first five writes as R3 and ends with 555h:10h.
- R5: Operation code 4 (identification) issues writes 555h:AAh, 2AAh:55h, 555h:90h and then reads address 000h and 001h. The first read byte lands on id_data_o[7:0] and the second on id_data_o[15:8], followed by a done pulse.
- R6: Operation code 0 and the unused codes 5, 6 and 7 issue a single write 000h:F0h, followed by a done pulse.
- R7: After the command writes of a program or erase, the block reads req_addr_i repeatedly until bit 7 of the read equals the expected bit (req_data_i[7] for program, 1 for either erase). It then pulses done_o for one cycle with err_o at 0.
- R8: A polling read with bit 5 at 1 and bit 7 mismatched is followed by exactly one more read. If that read matches, the request ends with done_o. Otherwise the block writes 000h:F0h and pulses err_o for one cycle with done_o at 0.
- R9: In every write, fl_dq_oe_o and a constant fl_addr_o/fl_dq_o are held for T_SETUP cycles before fl_we_no falls. fl_we_no stays low for T_PULSE cycles, and the drive holds for T_HOLD cycles after it rises. Reads pulse fl_oe_no low for T_PULSE cycles, and fl_we_no and fl_oe_no are never low together.
- R10: A request is taken on a cycle with req_valid_i and req_ready_o both high. req_ready_o then stays low through the done or error cycle, so a request held during that time is ignored. req_ready_o is high again in the cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Sequencer idle, request taken this cycle if valid |
| req_op_i | input | 3 | Operation code (see R2 to R6) |
| req_addr_i | input | AW | Target byte or sector address |
| req_data_i | input | 8 | Byte to program |
| done_o | output | 1 | One-cycle successful completion pulse |
| err_o | output | 1 | One-cycle timeout failure pulse |
| id_data_o | output | 16 | Identification bytes, offset 1 in upper byte |
| fl_addr_o | output | AW | Flash address bus |
| fl_dq_o | output | 8 | Flash write data |
| fl_dq_oe_o | output | 1 | Drive enable for write data |
| fl_dq_i | input | 8 | Flash read data |
| fl_we_no | output | 1 | Write strobe, active low |
| fl_oe_no | output | 1 | Output-enable strobe, active low |

## Verification
The done or error pulse of one request can fall in the same cycle as a following request already waiting on req_valid_i. The bench keeps req_valid_i high with a different operation from acceptance through the completion pulse and releases it only at that pulse. The request must be ignored: req_ready_o stays low until the cycle after the pulse, and the write log gains no extra entry. A second overlap is bit 5 and a still-wrong bit 7 showing up on the same polling read. A responder model in the bench provokes it at chosen read indices, and the read count, the return-to-read write and the pulse type are checked against values computed from R8.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [2:0] {
    OP_RST  = 3'd0,
    OP_PROG = 3'd1,
    OP_SERA = 3'd2,
    OP_CERA = 3'd3,
    OP_ID   = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_PULSE,
    PH_HOLD
  } phase_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CMD,
    S_POLL,
    S_POLL2,
    S_ID0,
    S_ID1,
    S_ABORT,
    S_FIN
  } seq_e;

  localparam logic [10:0] UNLOCK_A = 11'h555;
  localparam logic [10:0] UNLOCK_B = 11'h2AA;
  localparam logic [7:0]  KEY_A    = 8'hAA;
  localparam logic [7:0]  KEY_B    = 8'h55;
  localparam logic [7:0]  CMD_PROG = 8'hA0;
  localparam logic [7:0]  CMD_ERSU = 8'h80;
  localparam logic [7:0]  CMD_SERA = 8'h30;
  localparam logic [7:0]  CMD_CERA = 8'h10;
  localparam logic [7:0]  CMD_ID   = 8'h90;
  localparam logic [7:0]  CMD_RST  = 8'hF0;

endpackage

// File: rtl/flash_cmd_table.sv
module flash_cmd_table
  import flash_seq_pkg::*;
#(
  parameter int AW = 19
) (
  input  op_e           op_i,
  input  logic [2:0]    idx_i,
  input  logic [AW-1:0] tgt_addr_i,
  input  logic [7:0]    tgt_data_i,
  output logic [AW-1:0] addr_o,
  output logic [7:0]    data_o,
  output logic          last_o
);

  localparam logic [AW-1:0] A_UNL_A = AW'(UNLOCK_A);
  localparam logic [AW-1:0] A_UNL_B = AW'(UNLOCK_B);

  logic [2:0] last_idx;

  always_comb begin
    unique case (op_i)
      OP_PROG:          last_idx = 3'd3;
      OP_SERA, OP_CERA: last_idx = 3'd5;
      OP_ID:            last_idx = 3'd2;
      default:          last_idx = 3'd0;
    endcase
  end

  assign last_o = (idx_i == last_idx);

  always_comb begin
    addr_o = A_UNL_A;
    data_o = KEY_A;
    if (op_i == OP_RST) begin
      addr_o = '0;
      data_o = CMD_RST;
    end else begin
      unique case (idx_i)
        3'd1, 3'd4: begin
          addr_o = A_UNL_B;
          data_o = KEY_B;
        end
        3'd2: begin
          addr_o = A_UNL_A;
          data_o = (op_i == OP_PROG) ? CMD_PROG :
                   (op_i == OP_ID)   ? CMD_ID   : CMD_ERSU;
        end
        3'd3: begin
          if (op_i == OP_PROG) begin
            addr_o = tgt_addr_i;
            data_o = tgt_data_i;
          end
        end
        3'd5: begin
          if (op_i == OP_SERA) begin
            addr_o = tgt_addr_i;
            data_o = CMD_SERA;
          end else begin
            addr_o = A_UNL_A;
            data_o = CMD_CERA;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle
  import flash_seq_pkg::*;
#(
  parameter int AW      = 19,
  parameter int T_SETUP = 2,
  parameter int T_PULSE = 3,
  parameter int T_HOLD  = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  input  logic [7:0]    dq_i,
  output logic          done_o,
  output logic [7:0]    rdata_o,
  output logic [AW-1:0] addr_o,
  output logic [7:0]    dq_o,
  output logic          dq_oe_o,
  output logic          we_no,
  output logic          oe_no
);

  localparam int TMAX_SP = (T_SETUP > T_PULSE) ? T_SETUP : T_PULSE;
  localparam int TMAX    = (TMAX_SP > T_HOLD) ? TMAX_SP : T_HOLD;
  localparam int CW      = $clog2(TMAX + 1);

  phase_e        ph_q;
  logic [CW-1:0] cnt_q;
  logic          rd_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic [7:0]    rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      rd_q    <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      rdata_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (start_i) begin
          ph_q   <= PH_SETUP;
          cnt_q  <= CW'(T_SETUP - 1);
          rd_q   <= rd_i;
          addr_q <= addr_i;
          data_q <= data_i;
        end
        PH_SETUP: begin
          if (cnt_q == '0) begin
            ph_q  <= PH_PULSE;
            cnt_q <= CW'(T_PULSE - 1);
          end else cnt_q <= cnt_q - 1'b1;
        end
        PH_PULSE: begin
          if (cnt_q == '0) begin
            ph_q  <= PH_HOLD;
            cnt_q <= CW'(T_HOLD - 1);
            if (rd_q) rdata_q <= dq_i;  // sample before strobe release
          end else cnt_q <= cnt_q - 1'b1;
        end
        PH_HOLD: begin
          if (cnt_q == '0) ph_q <= PH_IDLE;
          else cnt_q <= cnt_q - 1'b1;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign done_o  = (ph_q == PH_HOLD) && (cnt_q == '0);
  assign rdata_o = rdata_q;
  assign addr_o  = addr_q;
  assign dq_o    = data_q;
  assign dq_oe_o = (ph_q != PH_IDLE) && !rd_q;
  assign we_no   = !((ph_q == PH_PULSE) && !rd_q);
  assign oe_no   = !((ph_q == PH_PULSE) && rd_q);

  a_r9_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_no && !oe_no));

  a_r9_drive_during_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> dq_oe_o);

  a_r9_bus_stable_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_no && $past(!we_no)) |-> ($stable(addr_o) && $stable(dq_o)));

endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int AW      = 19,
  parameter int T_SETUP = 2,
  parameter int T_PULSE = 3,
  parameter int T_HOLD  = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [2:0]    req_op_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [7:0]    req_data_i,
  output logic          done_o,
  output logic          err_o,
  output logic [15:0]   id_data_o,
  output logic [AW-1:0] fl_addr_o,
  output logic [7:0]    fl_dq_o,
  output logic          fl_dq_oe_o,
  input  logic [7:0]    fl_dq_i,
  output logic          fl_we_no,
  output logic          fl_oe_no
);

  seq_e          st_q;
  op_e           op_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic [2:0]    idx_q;
  logic          go_q;
  logic          err_q;
  logic [15:0]   id_q;

  op_e           op_in;
  logic [AW-1:0] tbl_addr;
  logic [7:0]    tbl_data;
  logic          tbl_last;
  logic          cyc_rd;
  logic [AW-1:0] cyc_addr;
  logic [7:0]    cyc_data;
  logic          cyc_done;
  logic [7:0]    cyc_rdata;
  logic          exp7;
  logic          hit;

  assign op_in = (req_op_i > 3'd4) ? OP_RST : op_e'(req_op_i);

  flash_cmd_table #(.AW(AW)) u_tbl (
    .op_i       (op_q),
    .idx_i      (idx_q),
    .tgt_addr_i (addr_q),
    .tgt_data_i (data_q),
    .addr_o     (tbl_addr),
    .data_o     (tbl_data),
    .last_o     (tbl_last)
  );

  always_comb begin
    cyc_rd   = 1'b0;
    cyc_addr = tbl_addr;
    cyc_data = tbl_data;
    unique case (st_q)
      S_POLL, S_POLL2: begin
        cyc_rd   = 1'b1;
        cyc_addr = addr_q;
      end
      S_ID0: begin
        cyc_rd   = 1'b1;
        cyc_addr = '0;
      end
      S_ID1: begin
        cyc_rd   = 1'b1;
        cyc_addr = AW'(1);
      end
      S_ABORT: begin
        cyc_addr = '0;
        cyc_data = CMD_RST;
      end
      default: ;
    endcase
  end

  flash_bus_cycle #(
    .AW(AW), .T_SETUP(T_SETUP), .T_PULSE(T_PULSE), .T_HOLD(T_HOLD)
  ) u_cyc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (go_q),
    .rd_i    (cyc_rd),
    .addr_i  (cyc_addr),
    .data_i  (cyc_data),
    .dq_i    (fl_dq_i),
    .done_o  (cyc_done),
    .rdata_o (cyc_rdata),
    .addr_o  (fl_addr_o),
    .dq_o    (fl_dq_o),
    .dq_oe_o (fl_dq_oe_o),
    .we_no   (fl_we_no),
    .oe_no   (fl_oe_no)
  );

  assign exp7 = (op_q == OP_PROG) ? data_q[7] : 1'b1;
  assign hit  = (cyc_rdata[7] == exp7);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      op_q   <= OP_RST;
      addr_q <= '0;
      data_q <= '0;
      idx_q  <= '0;
      go_q   <= 1'b0;
      err_q  <= 1'b0;
      id_q   <= '0;
    end else begin
      go_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (req_valid_i) begin
          op_q   <= op_in;
          addr_q <= req_addr_i;
          data_q <= req_data_i;
          idx_q  <= '0;
          err_q  <= 1'b0;
          go_q   <= 1'b1;
          st_q   <= S_CMD;
        end
        S_CMD: if (cyc_done) begin
          if (tbl_last) begin
            unique case (op_q)
              OP_PROG, OP_SERA, OP_CERA: begin
                st_q <= S_POLL;
                go_q <= 1'b1;
              end
              OP_ID: begin
                st_q <= S_ID0;
                go_q <= 1'b1;
              end
              default: st_q <= S_FIN;
            endcase
          end else begin
            idx_q <= idx_q + 1'b1;
            go_q  <= 1'b1;
          end
        end
        S_POLL: if (cyc_done) begin
          if (hit) st_q <= S_FIN;
          else begin
            if (cyc_rdata[5]) st_q <= S_POLL2;  // timeout flag: one confirming read
            go_q <= 1'b1;
          end
        end
        S_POLL2: if (cyc_done) begin
          if (hit) st_q <= S_FIN;
          else begin
            st_q <= S_ABORT;
            go_q <= 1'b1;
          end
        end
        S_ABORT: if (cyc_done) begin
          err_q <= 1'b1;
          st_q  <= S_FIN;
        end
        S_ID0: if (cyc_done) begin
          id_q[7:0] <= cyc_rdata;
          st_q      <= S_ID1;
          go_q      <= 1'b1;
        end
        S_ID1: if (cyc_done) begin
          id_q[15:8] <= cyc_rdata;
          st_q       <= S_FIN;
        end
        S_FIN: st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st_q == S_IDLE);
  assign done_o      = (st_q == S_FIN) && !err_q;
  assign err_o       = (st_q == S_FIN) && err_q;
  assign id_data_o   = id_q;

  a_r7_pulse_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));

  a_r10_ready_after_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |=> req_ready_o);

  a_r10_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  a_r8_err_follows_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(fl_we_no) && !$past(fl_dq_oe_o, 1) == 1'b0);

endmodule

// File: tb/sim_flash_seq.sv
module sim_flash_seq;

  localparam int AW = 19;
  localparam int TS = 2;
  localparam int TP = 3;
  localparam int TH = 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [2:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_data = '0;
  logic          done, err;
  logic [15:0]   id_data;
  logic [AW-1:0] fl_addr;
  logic [7:0]    fl_dq_o, fl_dq_i;
  logic          fl_dq_oe, fl_we_n, fl_oe_n;

  always #5 clk = ~clk;

  flash_seq #(.AW(AW), .T_SETUP(TS), .T_PULSE(TP), .T_HOLD(TH)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_addr_i(req_addr), .req_data_i(req_data),
    .done_o(done), .err_o(err), .id_data_o(id_data),
    .fl_addr_o(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_oe_o(fl_dq_oe),
    .fl_dq_i(fl_dq_i), .fl_we_no(fl_we_n), .fl_oe_no(fl_oe_n)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] got,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // responder model
  logic [AW-1:0] wr_a [1024];
  logic [7:0]    wr_d [1024];
  int wr_cnt = 0, rd_cnt = 0, rd_addr_err = 0;
  int m_rbase = 0, m_busy = 0, m_dq5 = 99;
  bit m_id = 0, m_exp7 = 1;
  logic [7:0] m_okv = 8'hFF;
  logic [AW-1:0] m_tgt = '0;

  always @(posedge fl_we_n) if (rst_n) begin
    wr_a[wr_cnt % 1024] = fl_addr;
    wr_d[wr_cnt % 1024] = fl_dq_o;
    wr_cnt++;
  end

  always @(posedge fl_oe_n) if (rst_n) begin
    if (!m_id && fl_addr != m_tgt) rd_addr_err++;
    rd_cnt++;
  end

  always_comb begin
    int k;
    k = rd_cnt - m_rbase;
    if (m_id) fl_dq_i = fl_addr[0] ? 8'hC3 : 8'h5A;
    else if (k < m_busy) fl_dq_i = {~m_exp7, k[0], (k >= m_dq5), 5'b0};
    else fl_dq_i = m_okv;
  end

  // strobe timing monitor
  int tim_err = 0, su_cnt = 0, lo_cnt = 0, ho_cnt = 0, olo_cnt = 0;
  bit prev_we = 1, prev_oe = 1, in_cyc = 0, fell = 0;
  logic [AW-1:0] a_fall;
  logic [7:0] d_fall;

  always @(negedge clk) if (rst_n) begin
    if (!fl_we_n && !fl_oe_n) tim_err++;
    if (fl_dq_oe && fl_we_n && !fell) su_cnt++;
    if (!fl_we_n) begin
      if (prev_we) begin
        if (su_cnt != TS) tim_err++;
        fell = 1; a_fall = fl_addr; d_fall = fl_dq_o;
      end
      if (!fl_dq_oe || fl_addr != a_fall || fl_dq_o != d_fall) tim_err++;
      lo_cnt++;
    end else if (!prev_we) begin
      if (lo_cnt != TP) tim_err++;
      lo_cnt = 0;
    end
    if (fell && fl_we_n && fl_dq_oe) begin
      if (fl_addr != a_fall || fl_dq_o != d_fall) tim_err++;
      ho_cnt++;
    end
    if (!fl_dq_oe && fell) begin
      if (ho_cnt != TH) tim_err++;
      fell = 0; ho_cnt = 0; su_cnt = 0;
    end
    if (!fl_dq_oe && !fell) su_cnt = 0;
    if (!fl_oe_n) olo_cnt++;
    else if (!prev_oe) begin
      if (olo_cnt != TP) tim_err++;
      olo_cnt = 0;
    end
    prev_we = fl_we_n;
    prev_oe = fl_oe_n;
  end

  function automatic void exp_wr(input int n, input int i, input logic [AW-1:0] a,
                                 input logic [7:0] d, output logic [AW-1:0] ea,
                                 output logic [7:0] ed);
    ea = AW'(11'h555); ed = 8'hAA;
    if (n == 0) begin ea = '0; ed = 8'hF0; end
    else case (i)
      1, 4: begin ea = AW'(11'h2AA); ed = 8'h55; end
      2: ed = (n == 1) ? 8'hA0 : (n == 4) ? 8'h90 : 8'h80;
      3: if (n == 1) begin ea = a; ed = d; end
      5: if (n == 2) begin ea = a; ed = 8'h30; end else ed = 8'h10;
      default: ;
    endcase
  endfunction

  bit wd_fail = 0;

  task automatic run_req(input int op, input logic [AW-1:0] a, input logic [7:0] d,
                         input int busy_n, input int dq5_at);
    int n, len, base_w, base_r, base_t, base_ra, exp_rd, cyc;
    bit exp_err, got_done, got_err;
    string tg;
    logic [AW-1:0] ea;
    logic [7:0] ed;
    n = (op > 4) ? 0 : op;
    len = (n == 0) ? 1 : (n == 1) ? 4 : (n == 4) ? 3 : 6;
    tg = (n == 0) ? "R6" : (n == 1) ? "R2" : (n == 2) ? "R3" : (n == 3) ? "R4" : "R5";
    @(negedge clk);
    base_w = wr_cnt; base_r = rd_cnt; base_t = tim_err; base_ra = rd_addr_err;
    m_rbase = rd_cnt; m_busy = busy_n; m_dq5 = dq5_at; m_id = (n == 4);
    m_exp7 = (n == 1) ? d[7] : 1'b1; m_okv = (n == 1) ? d : 8'hFF; m_tgt = a;
    req_valid = 1; req_op = 3'(op); req_addr = a; req_data = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    chk(!req_ready, "R10 busy after accept", 32'(req_ready), 0);
    req_op = 3'd3; req_addr = ~a;  // pending request, must be ignored
    cyc = 0;
    while (!(done || err) && cyc < 20000) begin @(negedge clk); cyc++; end
    if (cyc >= 20000) begin wd_fail = 1; chk(0, "watchdog", cyc, 0); end
    got_done = done; got_err = err;
    chk(!req_ready, "R10 not ready on pulse", 32'(req_ready), 0);
    req_valid = 0;
    @(negedge clk);
    chk(req_ready && !done && !err, "R10 ready after pulse",
        {done, err, req_ready}, 3'b001);
    repeat (4) @(negedge clk);
    exp_err = 0; exp_rd = 0;
    if (n >= 1 && n <= 3) begin
      if (dq5_at < busy_n) begin
        exp_rd = dq5_at + 2;
        exp_err = (dq5_at + 1 < busy_n);
      end else exp_rd = busy_n + 1;
    end else if (n == 4) exp_rd = 2;
    chk(wr_cnt - base_w == len + int'(exp_err), tg, wr_cnt - base_w, len + int'(exp_err));
    for (int i = 0; i < len; i++) begin
      exp_wr(n, i, a, d, ea, ed);
      chk(wr_a[(base_w + i) % 1024] == ea && wr_d[(base_w + i) % 1024] == ed, tg,
          {wr_a[(base_w + i) % 1024], wr_d[(base_w + i) % 1024]}, {ea, ed});
    end
    if (exp_err)
      chk(wr_a[(base_w + len) % 1024] == '0 && wr_d[(base_w + len) % 1024] == 8'hF0,
          "R8 abort write", wr_d[(base_w + len) % 1024], 8'hF0);
    chk(rd_cnt - base_r == exp_rd, exp_err || dq5_at < busy_n ? "R8 reads" : "R7 reads",
        rd_cnt - base_r, exp_rd);
    chk(got_done == !exp_err && got_err == exp_err, exp_err ? "R8 pulse" : "R7 pulse",
        {got_done, got_err}, {!exp_err, exp_err});
    chk(rd_addr_err == base_ra, "R7 poll address", rd_addr_err - base_ra, 0);
    chk(tim_err == base_t, "R9 strobe timing", tim_err - base_t, 0);
    if (n == 4) chk(id_data == 16'hC35A, "R5 id bytes", id_data, 16'hC35A);
  endtask

  initial begin
    #1500000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] pdat [5] = '{8'h00, 8'h7F, 8'h80, 8'hFF, 8'hA5};
    repeat (3) @(negedge clk);
    chk(req_ready && fl_we_n && fl_oe_n && !fl_dq_oe && !done && !err, "R1 reset state",
        {req_ready, fl_we_n, fl_oe_n, fl_dq_oe, done, err}, 6'b111000);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && fl_we_n && fl_oe_n && !fl_dq_oe && !done && !err, "R1 after release",
        {req_ready, fl_we_n, fl_oe_n, fl_dq_oe, done, err}, 6'b111000);
    for (int di = 0; di < 5; di++)
      for (int b = 0; b < 3; b++)
        run_req(1, AW'(32'h1234 * (di + 1) + b), pdat[di], b, 99);
    for (int op = 2; op <= 3; op++)
      for (int b = 0; b < 4; b++)
        run_req(op, AW'(32'h10000 * (b + 1)), 8'h00, b, 99);
    run_req(4, AW'(0), 8'h00, 0, 99);
    for (int op = 0; op < 8; op++)
      if (op == 0 || op > 4) run_req(op, AW'(op * 7), 8'h3C, 0, 99);
    run_req(1, AW'(32'h7FFFF), 8'h80, 1000, 0);  // R8 fail at first flag
    run_req(1, AW'(32'h00100), 8'h01, 1000, 2);  // R8 fail after busy reads
    run_req(1, AW'(32'h00200), 8'hC0, 1, 0);     // R8 confirming read succeeds
    run_req(2, AW'(32'h30000), 8'h00, 3, 2);     // R8 success on last confirm
    run_req(3, AW'(32'h00000), 8'h00, 1000, 1);  // R8 chip erase failure
    run_req(4, AW'(32'h00555), 8'h00, 0, 99);    // R5 after error
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule